// File: doc/BRIEF.md
# Serial Receive Frame Synchronizer

This block watches a one-bit serial receive stream (carrier-sense plus data, both sampled on the rising edge of the receive clock). It waits for carrier to rise and then lets a short settling delay pass. After that it hunts for an accepted preamble: an alternating run of bits closed by two ones. When the closing one arrives, it raises a one-cycle sync pulse. From the next bit until carrier falls, it presents each received bit with a valid strobe.

Any other bit pattern, or a carrier drop before sync, abandons the attempt. In that case a sticky error flag is set and the block ignores the stream until carrier rises again. The settling delay depends on how the previous burst ended. The block keeps a trailing-clock flag that records whether the receive clock kept running with carrier low after the last fall. When the flag is clear, the delay is one cycle shorter.

Top module: `rx_frame_sync`

## Requirements
- R1: While `rst` is high, and after the first clock edge with `rst` high, `sync_o`, `dval_o`, `dbit_o`, `err_o` and `trail_o` are all 0, and the block waits for a carrier rise.
- R2: A carrier rise is a clock edge where `crs_i` is 1 after having been 0 at the previous edge (or after reset). The first bit examined for the preamble is `rxd_i` sampled 3 edges after the rise edge when `trail_o` was 1 at the rise, and 2 edges after it when `trail_o` was 0.
- R3: The examined bit sequence 0, then n copies of 1,0, then 1,1, with n ≥ 3 (for example 0,1,0,1,0,1,0,1,1), produces `sync_o` = 1 for exactly the cycle after the edge that sampled the final 1.
- R4: The examined bit sequence 1,0, then n copies of 1,0, then 1,1, with n ≥ 3 (for example 1,0,1,0,1,0,1,0,1,1), also produces the sync pulse of R3.
- R5: Any other examined sequence gives no sync. Examples are two zeros in a row, or two ones after too short an alternating run (such as n = 2). After such a sequence, no `sync_o` and no `dval_o` appear until the next carrier rise, whatever bits follow.
- R6: After the sync pulse, each following edge with `crs_i` = 1 yields `dval_o` = 1 and `dbit_o` = that edge's `rxd_i` in the next cycle. The first edge with `crs_i` = 0 ends the frame. `dbit_o` is 0 whenever `dval_o` is 0.
- R7: `err_o` is set by a failed pattern (R5), or by `crs_i` = 0 before sync. It stays set, is cleared by the next carrier rise edge, and is never 1 during a sync pulse.
- R8: An edge with `crs_i` = 0 that follows an edge with `crs_i` = 1 clears `trail_o`. Every further edge with `crs_i` = 0 sets it.
- R9: `sync_o` is never high for two cycles in a row, and `sync_o` and `dval_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| crs_i | input | 1 | Carrier sense |
| rxd_i | input | 1 | Receive data bit |
| sync_o | output | 1 | One-cycle frame synchronization pulse |
| dval_o | output | 1 | Data-valid strobe for `dbit_o` |
| dbit_o | output | 1 | Received data bit passed downstream |
| err_o | output | 1 | Sticky flag: sync attempt failed or aborted |
| trail_o | output | 1 | Receive clock ran with carrier low after the last fall |

## Verification
A stale trailing-clock flag or a settling counter loaded with the wrong value shifts the hunt window by one bit. That shift makes a correctly timed preamble fail: `err_o` rises and `sync_o` never comes, within about ten cycles of the carrier rise. A run counter that is off by one shows up in the same frame, as a sync on an n = 2 preamble or no sync on an n = 3 one. A phase register stuck in the data state shows `dval_o` on the cycle after carrier falls. A missing lockout shows a sync pulse later in a burst that had already failed.

// File: rtl/fsync_pkg.sv
package fsync_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_HUNT   = 2'd2,
        PH_PASS   = 2'd3
    } rx_phase_e;

    typedef struct packed {
        logic hit;   // closing double-one seen after a long enough run
        logic miss;  // pattern broken
    } verdict_t;

    // Alternating bits required before the closing one, by leading bit.
    function automatic int run_need(input logic lead_bit, input int min_pairs);
        return lead_bit ? (2 * min_pairs + 3) : (2 * min_pairs + 2);
    endfunction

endpackage

// File: rtl/fsync_carrier_track.sv
module fsync_carrier_track (
    input  logic clk,
    input  logic rst,
    input  logic crs_i,
    output logic rise_o,
    output logic prev_o,
    output logic trail_o
);
    logic prev_q;
    logic trail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            trail_q <= 1'b0;
        end else begin
            prev_q <= crs_i;
            if (!crs_i) begin
                // first low edge after a high one clears, any later low edge sets
                trail_q <= !prev_q;
            end
        end
    end

    assign rise_o  = crs_i & ~prev_q;
    assign prev_o  = prev_q;
    assign trail_o = trail_q;
endmodule

// File: rtl/fsync_lat_timer.sv
module fsync_lat_timer #(
    parameter int SHORT_LAT = 2,
    parameter int LONG_LAT  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic long_i,
    input  logic run_i,
    output logic done_o
);
    localparam int MAX_LOAD = (LONG_LAT > SHORT_LAT ? LONG_LAT : SHORT_LAT) - 2;
    localparam int CW       = (MAX_LOAD > 0) ? $clog2(MAX_LOAD + 1) : 1;
    localparam logic [CW-1:0] LOAD_S = CW'(SHORT_LAT - 2);
    localparam logic [CW-1:0] LOAD_L = CW'(LONG_LAT - 2);

    generate
        if (MAX_LOAD == 0) begin : g_fixed
            assign done_o = 1'b1;
        end else begin : g_count
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q <= '0;
                end else if (load_i) begin
                    cnt_q <= long_i ? LOAD_L : LOAD_S;
                end else if (run_i && (cnt_q != '0)) begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
            assign done_o = (cnt_q == '0);
        end
    endgenerate
endmodule

// File: rtl/fsync_hunter.sv
module fsync_hunter
    import fsync_pkg::*;
#(
    parameter int MIN_PAIRS = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clr_i,
    input  logic     take_i,
    input  logic     bit_i,
    output verdict_t verdict_o
);
    localparam int SAT = 2 * MIN_PAIRS + 3;
    localparam int CW  = $clog2(SAT + 1);
    localparam logic [CW-1:0] NEED0 = CW'(run_need(1'b0, MIN_PAIRS));
    localparam logic [CW-1:0] NEED1 = CW'(run_need(1'b1, MIN_PAIRS));
    localparam logic [CW-1:0] SAT_V = CW'(SAT);

    logic          armed_q;
    logic          lead_q;
    logic          last_q;
    logic [CW-1:0] run_q;
    logic [CW-1:0] need;

    assign need = lead_q ? NEED1 : NEED0;

    always_comb begin
        verdict_o = '0;
        if (take_i && armed_q && (bit_i == last_q)) begin
            if (bit_i && (run_q >= need)) begin
                verdict_o.hit = 1'b1;
            end else begin
                verdict_o.miss = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            armed_q <= 1'b0;
            lead_q  <= 1'b0;
            last_q  <= 1'b0;
            run_q   <= '0;
        end else if (take_i) begin
            if (!armed_q) begin
                armed_q <= 1'b1;
                lead_q  <= bit_i;
                last_q  <= bit_i;
                run_q   <= CW'(1);
            end else begin
                last_q <= bit_i;
                if (run_q < SAT_V) begin
                    run_q <= run_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rx_frame_sync.sv
module rx_frame_sync
    import fsync_pkg::*;
#(
    parameter int MIN_PAIRS = 3,
    parameter int SHORT_LAT = 2,
    parameter int LONG_LAT  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic crs_i,
    input  logic rxd_i,
    output logic sync_o,
    output logic dval_o,
    output logic dbit_o,
    output logic err_o,
    output logic trail_o
);
    rx_phase_e phase_q;
    logic      crs_rise;
    logic      crs_prev;
    logic      settle_done;
    logic      hunt_take;
    verdict_t  verdict;

    logic sync_q, dval_q, dbit_q, err_q;

    fsync_carrier_track u_track (
        .clk     (clk),
        .rst     (rst),
        .crs_i   (crs_i),
        .rise_o  (crs_rise),
        .prev_o  (crs_prev),
        .trail_o (trail_o)
    );

    fsync_lat_timer #(
        .SHORT_LAT (SHORT_LAT),
        .LONG_LAT  (LONG_LAT)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load_i (crs_rise),
        .long_i (trail_o),
        .run_i  (phase_q == PH_SETTLE),
        .done_o (settle_done)
    );

    assign hunt_take = (phase_q == PH_HUNT) && crs_i && !crs_rise;

    fsync_hunter #(
        .MIN_PAIRS (MIN_PAIRS)
    ) u_hunt (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (crs_rise),
        .take_i    (hunt_take),
        .bit_i     (rxd_i),
        .verdict_o (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            sync_q  <= 1'b0;
            dval_q  <= 1'b0;
            dbit_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            sync_q <= 1'b0;
            dval_q <= 1'b0;
            dbit_q <= 1'b0;
            if (crs_rise) begin
                phase_q <= PH_SETTLE;
                err_q   <= 1'b0;
            end else begin
                unique case (phase_q)
                    PH_SETTLE: begin
                        if (!crs_i) begin
                            err_q   <= 1'b1;
                            phase_q <= PH_IDLE;
                        end else if (settle_done) begin
                            phase_q <= PH_HUNT;
                        end
                    end
                    PH_HUNT: begin
                        if (!crs_i) begin
                            err_q   <= 1'b1;
                            phase_q <= PH_IDLE;
                        end else if (verdict.hit) begin
                            sync_q  <= 1'b1;
                            phase_q <= PH_PASS;
                        end else if (verdict.miss) begin
                            err_q   <= 1'b1;
                            phase_q <= PH_IDLE;
                        end
                    end
                    PH_PASS: begin
                        if (crs_i) begin
                            dval_q <= 1'b1;
                            dbit_q <= rxd_i;
                        end else begin
                            phase_q <= PH_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sync_o = sync_q;
    assign dval_o = dval_q;
    assign dbit_o = dbit_q;
    assign err_o  = err_q;
endmodule

// File: rtl/rx_frame_sync_chk.sv
module rx_frame_sync_chk (
    input logic clk,
    input logic rst,
    input logic crs_i,
    input logic carrier_q,
    input logic sync_o,
    input logic dval_o,
    input logic err_o,
    input logic trail_o
);
    assert_sync_single_R9: assert property (@(posedge clk) disable iff (rst)
        sync_o |=> !sync_o);

    assert_sync_dval_apart_R9: assert property (@(posedge clk) disable iff (rst)
        !(sync_o && dval_o));

    assert_dval_carrier_R6: assert property (@(posedge clk) disable iff (rst)
        dval_o |-> $past(crs_i));

    assert_dval_after_sync_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(dval_o) |-> $past(sync_o));

    assert_sync_clean_R7: assert property (@(posedge clk) disable iff (rst)
        sync_o |-> !err_o);

    assert_trail_fall_R8: assert property (@(posedge clk) disable iff (rst)
        (carrier_q && !crs_i) |=> !trail_o);

    assert_trail_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!carrier_q && !crs_i) |=> trail_o);
endmodule

bind rx_frame_sync rx_frame_sync_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .crs_i     (crs_i),
    .carrier_q (crs_prev),
    .sync_o    (sync_o),
    .dval_o    (dval_o),
    .err_o     (err_o),
    .trail_o   (trail_o)
);

// File: tb/rx_frame_sync_tb.sv
`timescale 1ns/1ps
module rx_frame_sync_tb;
    localparam int MINP = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic crs_i = 1'b0;
    logic rxd_i = 1'b0;
    logic sync_o, dval_o, dbit_o, err_o, trail_o;

    always #2 clk = ~clk;

    rx_frame_sync u_dut (
        .clk(clk), .rst(rst), .crs_i(crs_i), .rxd_i(rxd_i),
        .sync_o(sync_o), .dval_o(dval_o), .dbit_o(dbit_o),
        .err_o(err_o), .trail_o(trail_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    int seen_sync = 0;
    int seen_dval = 0;
    bit after_rst = 1;

    // reference model state
    bit m_prev, m_trail, m_sync, m_dval, m_dbit, m_err;
    int m_phase, m_wait, hl;
    bit h [64];

    task automatic check(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_int(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit alt_ok(int upto);
        for (int i = 1; i < upto; i++)
            if (h[i] == h[i-1]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit complete_ok();
        if (hl < 2) return 1'b0;
        if (!(h[hl-1] && h[hl-2])) return 1'b0;
        if (!alt_ok(hl - 1)) return 1'b0;
        return hl >= (h[0] ? 2*MINP + 4 : 2*MINP + 3);
    endfunction

    task automatic model_take(bit b);
        h[hl] = b;
        if (hl < 63) hl++;
        if (complete_ok()) begin
            m_sync = 1; m_phase = 3;
        end else if (!alt_ok(hl)) begin
            m_err = 1; m_phase = 0;
        end
    endtask

    task automatic model_edge();
        bit rise;
        if (rst) begin
            m_prev = 0; m_trail = 0; m_sync = 0; m_dval = 0; m_dbit = 0;
            m_err = 0; m_phase = 0; m_wait = 0; hl = 0;
            return;
        end
        rise = crs_i && !m_prev;
        m_sync = 0; m_dval = 0; m_dbit = 0;
        if (rise) begin
            m_err = 0; m_phase = 1; m_wait = m_trail ? 3 : 2; hl = 0;
        end else if ((m_phase == 1 || m_phase == 2) && !crs_i) begin
            m_err = 1; m_phase = 0;
        end else if (m_phase == 1) begin
            m_wait--;
            if (m_wait == 0) begin
                m_phase = 2;
                model_take(rxd_i);
            end
        end else if (m_phase == 2) begin
            model_take(rxd_i);
        end else if (m_phase == 3) begin
            if (crs_i) begin m_dval = 1; m_dbit = rxd_i; end
            else m_phase = 0;
        end
        if (!crs_i) m_trail = !m_prev;
        m_prev = crs_i;
    endtask

    task automatic tick(bit c, bit d);
        crs_i = c; rxd_i = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (sync_o === 1'b1) seen_sync++;
        if (dval_o === 1'b1) seen_dval++;
        if (!rst) begin
            check("R3 sync_o", sync_o, m_sync);
            check("R6 dval_o", dval_o, m_dval);
            check("R6 dbit_o", dbit_o, m_dbit);
            check("R7 err_o", err_o, m_err);
            check("R8 trail_o", trail_o, m_trail);
        end
    endtask

    function automatic bit rbit();
        return bit'($urandom() % 2);
    endfunction

    // gap: low edges before the rise (0 = none, then lat_hint is used)
    task automatic send_frame(int gap, int lat_hint, int form, int n, int flip,
                              int skew, int plen, int cut);
        bit pb [64];
        int pl = 0;
        int lat;
        for (int i = 0; i < gap; i++) tick(0, rbit());
        if (gap > 0) lat = (gap == 1 && !after_rst) ? 2 : 3;
        else lat = lat_hint;
        after_rst = 0;
        if (form == 1) begin pb[pl++] = 1; pb[pl++] = 0; end
        else pb[pl++] = 0;
        for (int i = 0; i < n; i++) begin pb[pl++] = 1; pb[pl++] = 0; end
        pb[pl++] = 1; pb[pl++] = 1;
        if (flip >= 0 && flip < pl) pb[flip] = !pb[flip];
        for (int i = 0; i < lat + skew; i++) tick(1, 0);
        for (int k = 0; k < pl; k++) begin
            if (k == cut) return;
            tick(1, pb[k]);
        end
        for (int k = 0; k < plen; k++) tick(1, rbit());
    endtask

    initial begin
        int s0, d0;
        void'($urandom(32'h1F2E3D4C));
        rst = 1'b1;
        for (int i = 0; i < 3; i++) tick(0, 0);
        // R1 reset state
        check("R1 sync_o reset", sync_o, 0);
        check("R1 dval_o reset", dval_o, 0);
        check("R1 dbit_o reset", dbit_o, 0);
        check("R1 err_o reset", err_o, 0);
        check("R1 trail_o reset", trail_o, 0);
        rst = 1'b0;

        // R3 + R2 (long settle after reset idle)
        s0 = seen_sync;
        send_frame(2, 0, 0, 3, -1, 0, 6, -1);
        check_int("R3 form-a n=3 sync count", seen_sync - s0, 1);

        // R8: one low edge after high -> trail clear, then R4 with short settle (R2)
        tick(0, 0);
        check("R8 trail after single low edge", trail_o, 0);
        s0 = seen_sync;
        send_frame(0, 2, 1, 3, -1, 0, 5, -1);
        check_int("R4 form-b n=3 sync count (R2 short)", seen_sync - s0, 1);

        // R2: one extra settle bit misaligns the hunt -> fail
        tick(0, 0);
        s0 = seen_sync;
        send_frame(0, 2, 0, 3, -1, 1, 0, -1);
        check_int("R2 skewed start gives no sync", seen_sync - s0, 0);
        check("R2 skewed start sets err", err_o, 1);

        // R8 trail set by extra low edges; R5 short run fails and locks out
        tick(0, 0); tick(0, 0); tick(0, 0);
        check("R8 trail after extra low edges", trail_o, 1);
        s0 = seen_sync; d0 = seen_dval;
        send_frame(0, 3, 0, 2, -1, 0, 0, -1);
        check_int("R5 n=2 gives no sync", seen_sync - s0, 0);
        check("R5 n=2 sets err", err_o, 1);
        for (int k = 0; k < 13; k++) tick(1, (k == 0) ? 1'b0 : ((k % 2 == 1) || k == 12));
        check_int("R5 lockout ignores later preamble", seen_sync - s0, 0);
        check_int("R5 lockout no data", seen_dval - d0, 0);

        // R7: rise clears err; drop during hunt sets it
        tick(0, 0);
        send_frame(0, 2, 1, 4, -1, 0, 0, 5);
        check("R7 err cleared by rise", err_o, 0);
        tick(0, 0);
        check("R7 err set by carrier drop in hunt", err_o, 1);

        // R6 payload count
        d0 = seen_dval;
        send_frame(2, 0, 0, 5, -1, 0, 9, -1);
        tick(0, 0);
        check_int("R6 dval count equals payload", seen_dval - d0, 9);
        check("R6 dval low after carrier drop", dval_o, 0);

        // random frames
        for (int f = 0; f < 150; f++) begin
            int gap = 1 + int'($urandom() % 4);
            int form = int'($urandom() % 2);
            int n = 2 + int'($urandom() % 5);
            int flip = ($urandom() % 4 == 0) ? int'($urandom() % 18) : -1;
            int skew = ($urandom() % 8 == 0) ? 1 : 0;
            int plen = int'($urandom() % 13);
            int cut = ($urandom() % 8 == 0) ? int'($urandom() % 10) : -1;
            send_frame(gap, 0, form, n, flip, skew, plen, cut);
        end
        for (int i = 0; i < 3; i++) tick(0, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule